// File: doc/BRIEF.md
# Asynchronous SRAM Write-Read Sequencer

This block lets a clocked host issue single read or write accesses to an external asynchronous static RAM of 16K words by 4 bits. A request carries an address, write data, a read/write flag and two per-access style bits. It is taken on a valid/ready handshake. The sequencer then plays out a registered strobe sequence on the memory pins (chip select, write enable and output enable, all active low), drives or releases the data bus, and reports completion with a one-cycle response pulse that also carries read data.

Every phase length is a parameter counted in clock cycles. These cover address setup, the minimum write pulse, the time the memory needs to turn off its outputs, data setup, recovery and read access. There are two write styles. In the write-enable style, chip select falls at address setup and write enable forms the pulse. In the chip-select style, write enable falls at address setup and chip select forms the pulse. The memory outputs then never turn on, so the data bus can be driven from the first cycle. If the host asks for output enable to stay low during a write-enable-style write, the pulse is stretched to cover the output turn-off time plus data setup, and the data drivers stay off for the turn-off part. While idle, all strobes are high, which keeps the memory in standby.

Top module: `asram_seq`

## Requirements
- R1: While idle and during reset, `req_ready` is 1, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A request is accepted only on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the response cycle, and `req_valid` pulses while busy start no access. `req_ready` is 1 in the cycle after the response.
- R3: `mem_addr` equals the accepted address for the whole access. It changes only on an edge where `mem_cs_n` or `mem_we_n` is 1 both before and after the edge.
- R4: A read (`req_write`=0) keeps all strobes high for SETUP_CYC cycles. It then holds `mem_cs_n` and `mem_oe_n` low with `mem_we_n` high for ACCESS_CYC cycles and captures `mem_dq_in` on the last of them. The capture appears on `rsp_rdata` with the response. `req_oe_low` has no effect on reads.
- R5: A write-enable-style write (`req_cs_style`=0, `req_oe_low`=0) holds `mem_cs_n` low for SETUP_CYC+W cycles, where W = max(PULSE_CYC, DSU_CYC). `mem_we_n` is low for the last W of those cycles, with data driven for all W cycles and `mem_oe_n` high throughout.
- R6: A write-enable-style write with `req_oe_low`=1 holds `mem_oe_n` and `mem_cs_n` low for SETUP_CYC+L cycles, where L = max(PULSE_CYC, OEOFF_CYC+DSU_CYC). `mem_we_n` is low for the last L cycles, and data is driven only in the last L-OEOFF_CYC of them.
- R7: A chip-select-style write (`req_cs_style`=1) lowers `mem_we_n` and drives data from the first setup cycle, with `mem_cs_n` high. It then holds `mem_cs_n` low for W cycles with `mem_oe_n` high. `req_oe_low` is ignored in this style.
- R8: After the strobe phase, all strobes are high and the drivers are off for RECOV_CYC cycles. The data drivers turn off on the same edge that ends the write overlap.
- R9: Each access yields exactly one one-cycle `rsp_valid` pulse, SETUP_CYC + strobe length + RECOV_CYC + 1 cycles after the accept edge. A write leaves `rsp_rdata` unchanged.
- R10: `mem_dq_oe` is 1 only while `mem_oe_n` is 1 or `mem_we_n` is 0, so the controller never drives against the memory outputs.
- R11: Every write overlap (both `mem_cs_n` and `mem_we_n` low) lasts at least PULSE_CYC and at least DSU_CYC cycles. The word written is the data driven at its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_cs_style | input | 1 | 1 = chip select forms the write pulse, 0 = write enable forms it |
| req_oe_low | input | 1 | Keep output enable low during a write-enable-style write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Data captured by the latest read |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | DATA_W | Data toward the bidirectional pad |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_in | input | DATA_W | Data from the bidirectional pad |

## Verification
The bench builds the sequencer with SETUP_CYC=2, PULSE_CYC=3, OEOFF_CYC=2, DSU_CYC=2, RECOV_CYC=1 and ACCESS_CYC=3. With these values the output-enable-low stretch gives a visibly longer pulse (4 cycles against 3). The late-drive window (2 cycles) differs from the full pulse, and multi-cycle setup separates the style-dependent strobe that falls at setup from the one that forms the pulse. A bench memory model commits words at the end of each overlap, so read-back of random and corner addresses (0 and 3FFF) tests the whole write path through the pins.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_TURNOFF = 3'd2,
    ST_STROBE  = 3'd3,
    ST_RECOVER = 3'd4,
    ST_DONE    = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic drv;
  } pin_set_t;

  localparam pin_set_t PINS_QUIET = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

endpackage

// File: rtl/asram_timer.sv
`timescale 1ns/1ps
module asram_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/asram_pins.sv
`timescale 1ns/1ps
module asram_pins
  import asram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e st_next,
  input  logic       is_wr,
  input  logic       cs_style,
  input  logic       oe_low,
  output pin_set_t   pins_q
);
  pin_set_t pins_d;

  always_comb begin
    pins_d = PINS_QUIET;
    unique case (st_next)
      ST_SETUP: begin
        if (is_wr && cs_style) begin
          pins_d.we_n = 1'b0;
          pins_d.drv  = 1'b1;
        end else if (is_wr) begin
          pins_d.cs_n = 1'b0;
          pins_d.oe_n = ~oe_low;
        end
      end
      ST_TURNOFF: begin
        pins_d.cs_n = 1'b0;
        pins_d.we_n = 1'b0;
        pins_d.oe_n = 1'b0;
      end
      ST_STROBE: begin
        pins_d.cs_n = 1'b0;
        if (!is_wr) begin
          pins_d.oe_n = 1'b0;
        end else begin
          pins_d.we_n = 1'b0;
          pins_d.drv  = 1'b1;
          pins_d.oe_n = cs_style ? 1'b1 : ~oe_low;
        end
      end
      default: pins_d = PINS_QUIET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= PINS_QUIET;
    else        pins_q <= pins_d;
  end
endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 4,
  parameter int SETUP_CYC   = 1,
  parameter int PULSE_CYC   = 2,
  parameter int OEOFF_CYC   = 1,
  parameter int DSU_CYC     = 2,
  parameter int RECOV_CYC   = 1,
  parameter int ACCESS_CYC  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_cs_style,
  input  logic              req_oe_low,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  // Derived phase lengths
  localparam int WP_CYC   = (PULSE_CYC > DSU_CYC) ? PULSE_CYC : DSU_CYC;
  localparam int LATE_CYC = (PULSE_CYC > OEOFF_CYC + DSU_CYC) ? PULSE_CYC - OEOFF_CYC : DSU_CYC;
  localparam int M1 = (SETUP_CYC > WP_CYC) ? SETUP_CYC : WP_CYC;
  localparam int M2 = (OEOFF_CYC > LATE_CYC) ? OEOFF_CYC : LATE_CYC;
  localparam int M3 = (RECOV_CYC > ACCESS_CYC) ? RECOV_CYC : ACCESS_CYC;
  localparam int M12 = (M1 > M2) ? M1 : M2;
  localparam int MAX_LEN = (M12 > M3) ? M12 : M3;
  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam int OV_W  = CNT_W + 1;

  // Reset release synchronizer
  logic rst_sync_n;
  generate
    if (SYNC_STAGES <= 1) begin : g_rs1
      logic rs_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= 1'b0;
        else        rs_q <= 1'b1;
      end
      assign rst_sync_n = rs_q;
    end else begin : g_rsn
      logic [SYNC_STAGES-1:0] rs_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_sync_n = rs_q[SYNC_STAGES-1];
    end
  endgenerate

  seq_state_e state_q, state_d;
  logic op_wr_q, op_cs_q, op_oel_q;
  logic op_wr_d, op_cs_d, op_oel_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic rsp_q;
  logic accept, t_load, t_expired, cap_en;
  logic [CNT_W-1:0] t_val;
  pin_set_t pins;

  function automatic logic [CNT_W-1:0] strobe_len(input logic wr, input logic cs_st, input logic oel);
    if (!wr)              return CNT_W'(ACCESS_CYC - 1);
    else if (!cs_st && oel) return CNT_W'(LATE_CYC - 1);
    else                  return CNT_W'(WP_CYC - 1);
  endfunction

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign op_wr_d   = accept ? req_write    : op_wr_q;
  assign op_cs_d   = accept ? req_cs_style : op_cs_q;
  assign op_oel_d  = accept ? req_oe_low   : op_oel_q;

  // Next-state process
  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_SETUP;
        t_load  = 1'b1;
        t_val   = CNT_W'(SETUP_CYC - 1);
      end
      ST_SETUP: if (t_expired) begin
        t_load = 1'b1;
        if (op_wr_q && !op_cs_q && op_oel_q) begin
          state_d = ST_TURNOFF;
          t_val   = CNT_W'(OEOFF_CYC - 1);
        end else begin
          state_d = ST_STROBE;
          t_val   = strobe_len(op_wr_q, op_cs_q, op_oel_q);
        end
      end
      ST_TURNOFF: if (t_expired) begin
        state_d = ST_STROBE;
        t_load  = 1'b1;
        t_val   = CNT_W'(LATE_CYC - 1);
      end
      ST_STROBE: if (t_expired) begin
        state_d = ST_RECOVER;
        t_load  = 1'b1;
        t_val   = CNT_W'(RECOV_CYC - 1);
      end
      ST_RECOVER: if (t_expired) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign cap_en = (state_q == ST_STROBE) && t_expired && !op_wr_q;

  // Register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      op_wr_q  <= 1'b0;
      op_cs_q  <= 1'b0;
      op_oel_q <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rsp_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      rsp_q   <= (state_d == ST_DONE);
      if (accept) begin
        op_wr_q  <= op_wr_d;
        op_cs_q  <= op_cs_d;
        op_oel_q <= op_oel_d;
        addr_q   <= req_addr;
        wdata_q  <= req_wdata;
      end
      if (cap_en) rdata_q <= mem_dq_in;
    end
  end

  asram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  asram_pins u_pins (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .st_next  (state_d),
    .is_wr    (op_wr_d),
    .cs_style (op_cs_d),
    .oe_low   (op_oel_d),
    .pins_q   (pins)
  );

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_cs_n   = pins.cs_n;
  assign mem_we_n   = pins.we_n;
  assign mem_oe_n   = pins.oe_n;
  assign mem_dq_oe  = pins.drv;
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;

  // Overlap length observer for the pulse-width assertion
  logic [OV_W-1:0] ov_cnt;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)                ov_cnt <= '0;
    else if (!mem_cs_n && !mem_we_n) ov_cnt <= ov_cnt + 1'b1;
    else                            ov_cnt <= '0;
  end

  a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r3_addr_move_safe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(mem_addr) |-> (($past(mem_cs_n) && mem_cs_n) || ($past(mem_we_n) && mem_we_n)));

  a_r8_release_at_end: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(!mem_cs_n && !mem_we_n) && (mem_cs_n || mem_we_n)) |-> !mem_dq_oe);

  a_r9_single_rsp: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_dq_oe |-> (mem_oe_n || !mem_we_n));

  a_r11_min_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((ov_cnt != '0) && (mem_cs_n || mem_we_n)) |->
      ((ov_cnt >= OV_W'(PULSE_CYC)) && (ov_cnt >= OV_W'(DSU_CYC))));
endmodule

// File: tb/asram_seq_test.sv
`timescale 1ns/1ps
module asram_seq_test;
  localparam int S  = 2;
  localparam int P  = 3;
  localparam int OF = 2;
  localparam int D  = 2;
  localparam int RC = 1;
  localparam int A  = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write, req_cs_style, req_oe_low;
  logic [13:0] req_addr;
  logic [3:0]  req_wdata;
  logic rsp_valid;
  logic [3:0] rsp_rdata;
  logic [13:0] mem_addr;
  logic mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [3:0] mem_dq_out, mem_dq_in;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  asram_seq #(
    .SETUP_CYC(S), .PULSE_CYC(P), .OEOFF_CYC(OF), .DSU_CYC(D),
    .RECOV_CYC(RC), .ACCESS_CYC(A)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_cs_style(req_cs_style), .req_oe_low(req_oe_low),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Memory model: commits at the end of a strobe overlap
  logic [3:0] mdl [int];
  logic [3:0] ref_mem [int];
  logic prev_ov = 1'b0;
  logic [3:0] wbuf = '0;
  int dcnt = 0;
  int setup_bad = 0;
  logic [13:0] ov_addr = '0;

  always @(negedge clk) begin
    logic ov;
    ov = !mem_cs_n && !mem_we_n;
    if (ov) begin
      ov_addr = mem_addr;
      if (mem_dq_oe) begin wbuf = mem_dq_out; dcnt = dcnt + 1; end
      else dcnt = 0;
    end
    if (prev_ov && !ov) begin
      mdl[int'(ov_addr)] = wbuf;
      if (dcnt < D) setup_bad = setup_bad + 1;
      dcnt = 0;
    end
    prev_ov = ov;
    if (!mem_cs_n && !mem_oe_n && mem_we_n)
      mem_dq_in = mdl.exists(int'(mem_addr)) ? mdl[int'(mem_addr)] : 4'h0;
    else
      mem_dq_in = 4'h0;
  end

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int strobe_cycles(input bit w, input bit cs, input bit oel);
    if (!w) return A;
    if (!cs && oel) return mx(P, OF + D);
    return mx(P, D);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [3:0] last_rd = 4'h0;

  task automatic do_req(input bit w, input logic [13:0] a, input logic [3:0] d,
                        input bit cs, input bit oel, input bit junk);
    int n_cs, n_we, n_oe, n_ov, n_drv, n_rdy, n_abad, n_cont, lat;
    int st, exp_cs, exp_we, exp_oe, exp_drv;
    n_cs = 0; n_we = 0; n_oe = 0; n_ov = 0; n_drv = 0;
    n_rdy = 0; n_abad = 0; n_cont = 0; lat = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    req_cs_style = cs; req_oe_low = oel;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k < 100; k++) begin
      if (junk && k == 2) begin
        req_valid = 1'b1; req_addr = ~a; req_wdata = ~d;
      end
      if (!mem_cs_n) n_cs++;
      if (!mem_we_n) n_we++;
      if (!mem_oe_n) n_oe++;
      if (!mem_cs_n && !mem_we_n) n_ov++;
      if (mem_dq_oe) n_drv++;
      if (req_ready) n_rdy++;
      if (mem_addr != a) n_abad++;
      if (mem_dq_oe && !mem_cs_n && !mem_oe_n && mem_we_n) n_cont++;
      if (rsp_valid) begin lat = k; break; end
      @(negedge clk);
    end
    req_valid = 1'b0;
    st = strobe_cycles(w, cs, oel);
    chk(lat == S + st + RC + 1, "R9 latency", lat, S + st + RC + 1);
    chk(n_rdy == 0, "R2 ready low while busy", n_rdy, 0);
    chk(n_abad == 0, "R3 address held", n_abad, 0);
    chk(n_cont == 0, "R10 no contention", n_cont, 0);
    if (!w) begin
      exp_cs = A; exp_we = 0; exp_oe = A; exp_drv = 0;
    end else if (cs) begin
      exp_cs = st; exp_we = S + st; exp_oe = 0; exp_drv = S + st;
    end else if (oel) begin
      exp_cs = S + st; exp_we = st; exp_oe = S + st; exp_drv = st - OF;
    end else begin
      exp_cs = S + st; exp_we = st; exp_oe = 0; exp_drv = st;
    end
    if (!w) begin
      chk(n_cs == exp_cs, "R4 read cs low cycles", n_cs, exp_cs);
      chk(n_oe == exp_oe && n_we == 0, "R4 read oe low cycles", n_oe, exp_oe);
      chk(rsp_rdata == ref_mem[int'(a)], "R4 read data", rsp_rdata, ref_mem[int'(a)]);
      last_rd = rsp_rdata;
    end else begin
      string tag;
      tag = cs ? "R7" : (oel ? "R6" : "R5");
      chk(n_cs == exp_cs, {tag, " cs low cycles"}, n_cs, exp_cs);
      chk(n_we == exp_we, {tag, " we low cycles"}, n_we, exp_we);
      chk(n_oe == exp_oe, {tag, " oe low cycles"}, n_oe, exp_oe);
      chk(n_drv == exp_drv, {tag, " data drive cycles"}, n_drv, exp_drv);
      chk(n_ov == st, "R11 overlap length", n_ov, st);
      chk(rsp_rdata == last_rd, "R9 write keeps rdata", rsp_rdata, last_rd);
      ref_mem[int'(a)] = d;
    end
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R2 ready after response", req_ready, 1);
    chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R8 strobes quiet after access",
        {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    for (int i = 0; i < 16384; i += 1365) ref_mem[i] = 4'h0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; req_cs_style = 1'b0; req_oe_low = 1'b0;
    repeat (4) @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 reset ready", req_ready, 1);
    chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 reset strobes",
        {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(req_ready && mem_cs_n && mem_we_n && !mem_dq_oe && !rsp_valid, "R1 idle standby", req_ready, 1);

    ref_mem[0] = 4'h0; ref_mem[16'h3FFF] = 4'h0; ref_mem[16'h1234] = 4'h0;
    // Directed corners
    do_req(1'b0, 14'h0000, 4'h0, 1'b0, 1'b1, 1'b0);   // R4 read, oe_low ignored
    do_req(1'b1, 14'h0000, 4'hA, 1'b0, 1'b0, 1'b0);   // R5
    do_req(1'b1, 14'h3FFF, 4'h5, 1'b1, 1'b0, 1'b0);   // R7
    do_req(1'b1, 14'h1234, 4'hC, 1'b0, 1'b1, 1'b1);   // R6 with busy pulses (R2)
    do_req(1'b1, 14'h2222, 4'h9, 1'b1, 1'b1, 1'b0);   // R7 oe_low ignored
    do_req(1'b0, 14'h0000, 4'h0, 1'b0, 1'b0, 1'b0);
    do_req(1'b0, 14'h3FFF, 4'h0, 1'b0, 1'b0, 1'b0);
    do_req(1'b0, 14'h1234, 4'h0, 1'b0, 1'b0, 1'b0);
    do_req(1'b0, 14'h2222, 4'h0, 1'b0, 1'b0, 1'b1);
    chk(!mdl.exists(int'(~14'h1234)), "R2 busy request ignored", mdl.exists(int'(~14'h1234)), 0);

    // Random mix over a small address pool so reads hit written words
    for (int i = 0; i < 120; i++) begin
      logic [13:0] a;
      bit w;
      a = 14'($urandom_range(0, 15)) | ($urandom_range(0, 1) ? 14'h3FF0 : 14'h0000);
      if (!ref_mem.exists(int'(a))) ref_mem[int'(a)] = 4'h0;
      w = $urandom_range(0, 1);
      do_req(w, a, 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
    end
    chk(setup_bad == 0, "R11 data setup before write end", setup_bad, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule